// File: doc/BRIEF.md
# Dual-Code ECC Memory Controller

This block sits between a processor's memory port and a 512-word internal memory. Every stored word carries 32 data bits and 7 check bits. A write encodes the incoming data with the code currently chosen for the encoder and stores data and check bits in one cycle. A read recomputes the check bits from the stored data with the code chosen for the decoder and compares them with the stored ones to form a syndrome. The data then comes back clean, corrected, or flagged as uncorrectable.

Two codes of identical redundancy are built in, so the stored word never changes width. Both are SEC-DED codes with odd-weight columns: each data bit has a distinct weight-3 column, and each check bit has a unit column. The encoder and the decoder take their code choices from separate inputs, so the memory can be switched from one code to the other while it is being rewritten. After a corrected read, the controller spends one more cycle writing the re-encoded word back to the same address and holds the processor with a busy output during that cycle. Each correction reports the bit position and the address to an outside error monitor. A flip mask on the write path lets tests place faults in the stored word.

Top module: `dual_code_ecc_ctrl`

## Requirements
- R1: After reset, busy, rvalid, err_det and corr_valid are low.
- R2: A read request accepted while busy is low gives rvalid high in the next cycle. When the syndrome is zero, rdata equals the stored data and busy, err_det and corr_valid stay low.
- R3: Code 0 gives data bit i the i-th smallest 7-bit value of weight three, and code 1 gives it the i-th largest such value. Check bit j (stored at word bit 32+j) has column 1<<j. The stored check field is the XOR of the columns of the set data bits.
- R4: When exactly one data bit i of the stored word is wrong, rdata carries the corrected data, corr_valid is high, corr_pos equals i (0 to 31) and corr_addr equals the read address.
- R5: When exactly one check bit j is wrong, rdata equals the stored data, corr_valid is high and corr_pos equals 32+j.
- R6: busy is high for exactly the one cycle after a corrected read. In that cycle the corrected data, re-encoded with the active encoder code, is written back to the same address, so the next read of that address is clean.
- R7: When the syndrome is nonzero and does not match any single-bit column (any even-weight syndrome, for example), err_det rises together with rvalid, corr_valid and busy stay low, and nothing is written back.
- R8: enc_sel and dec_sel are independent and each takes effect from the clock edge after it is sampled. An access issued in the same cycle as a change still uses the old code.
- R9: A request (read or write) presented while busy is high is ignored: no rvalid in the next cycle and no change to the memory.
- R10: On a write, the flip input (bit k maps to stored word bit k) is XORed into the encoded word before it is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_sel | input | 1 | Code choice for the encoder (0 or 1) |
| dec_sel | input | 1 | Code choice for the decoder (0 or 1) |
| req | input | 1 | Access request |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 9 | Word address |
| wdata | input | 32 | Write data |
| flip | input | 39 | Fault mask XORed into the stored word on writes |
| rdata | output | 32 | Read data, corrected when possible |
| rvalid | output | 1 | Read result valid |
| err_det | output | 1 | Uncorrectable error on this read |
| busy | output | 1 | Write-back in progress, processor must stall |
| corr_valid | output | 1 | A single-bit error was corrected on this read |
| corr_pos | output | 6 | Corrected bit: 0-31 data, 32-38 check |
| corr_addr | output | 9 | Address of the corrected word |

## Verification
The write-back cycle and a fresh processor request can land in the same cycle. The bench provokes this by presenting a write to a known address, and separately a read, in exactly the cycle where busy is high after a corrected read. It judges the outcome by seeing no rvalid and by reading the untouched address back afterwards. A code-choice change and an access can also coincide. The bench changes dec_sel in the same cycle as a read request and expects the old decoder to judge that read.

// File: rtl/dual_code_ecc_ctrl.sv
module dual_code_ecc_ctrl #(
  parameter int DW    = 32,
  parameter int CW    = 7,
  parameter int DEPTH = 512,
  localparam int AW = $clog2(DEPTH),
  localparam int WW = DW + CW,
  localparam int PW = $clog2(WW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enc_sel,
  input  logic          dec_sel,
  input  logic          req,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [WW-1:0] flip,
  output logic [DW-1:0] rdata,
  output logic          rvalid,
  output logic          err_det,
  output logic          busy,
  output logic          corr_valid,
  output logic [PW-1:0] corr_pos,
  output logic [AW-1:0] corr_addr
);

  function automatic logic [DW*CW-1:0] build_cols(input logic desc);
    logic [DW*CW-1:0] r;
    logic [CW-1:0]    v;
    int               n;
    int               w;
    r = '0;
    n = 0;
    for (int k = 0; k < (1 << CW); k++) begin
      v = desc ? CW'((1 << CW) - 1 - k) : CW'(k);
      w = 0;
      for (int b = 0; b < CW; b++) w += int'(v[b]);
      if (w == 3 && n < DW) begin
        r[n*CW +: CW] = v;
        n++;
      end
    end
    return r;
  endfunction

  localparam logic [DW*CW-1:0] COLS0 = build_cols(1'b0);
  localparam logic [DW*CW-1:0] COLS1 = build_cols(1'b1);

  function automatic logic [CW-1:0] col(input logic sel, input int i);
    return sel ? COLS1[i*CW +: CW] : COLS0[i*CW +: CW];
  endfunction

  function automatic logic [CW-1:0] encode(input logic [DW-1:0] d, input logic sel);
    logic [CW-1:0] c;
    c = '0;
    for (int i = 0; i < DW; i++)
      if (d[i]) c ^= col(sel, i);
    return c;
  endfunction

  logic [WW-1:0] mem [DEPTH];
  logic          enc_q, dec_q;
  logic [AW-1:0] wb_addr;
  logic [DW-1:0] wb_data;

  logic [WW-1:0] rd_word;
  logic [CW-1:0] syn;
  logic [DW-1:0] fix_data;
  logic [PW-1:0] pos;
  logic          fixable, uncorr;

  wire accept  = req & ~busy;
  wire rd_fire = accept & ~we;

  assign rd_word = mem[addr];
  assign syn     = rd_word[WW-1:DW] ^ encode(rd_word[DW-1:0], dec_q);

  always_comb begin
    fix_data = rd_word[DW-1:0];
    pos      = '0;
    fixable  = 1'b0;
    uncorr   = 1'b0;
    if (syn != '0) begin
      if ($countones(syn) == 1) begin
        for (int j = 0; j < CW; j++)
          if (syn[j]) pos = PW'(DW + j);
        fixable = 1'b1;
      end else if ($countones(syn) % 2 == 1) begin
        for (int i = 0; i < DW; i++)
          if (syn == col(dec_q, i)) begin
            pos         = PW'(i);
            fix_data[i] = ~fix_data[i];
            fixable     = 1'b1;
          end
      end
      uncorr = ~fixable;
    end
  end

  always_ff @(posedge clk) begin
    if (busy)
      mem[wb_addr] <= {encode(wb_data, enc_q), wb_data};
    else if (req && we)
      mem[addr] <= {encode(wdata, enc_q), wdata} ^ flip;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enc_q      <= 1'b0;
      dec_q      <= 1'b0;
      busy       <= 1'b0;
      rvalid     <= 1'b0;
      err_det    <= 1'b0;
      corr_valid <= 1'b0;
      rdata      <= '0;
      corr_pos   <= '0;
      corr_addr  <= '0;
      wb_addr    <= '0;
      wb_data    <= '0;
    end else begin
      enc_q      <= enc_sel;
      dec_q      <= dec_sel;
      rvalid     <= rd_fire;
      err_det    <= rd_fire & uncorr;
      corr_valid <= rd_fire & fixable;
      busy       <= rd_fire & fixable;
      if (rd_fire) rdata <= fix_data;
      if (rd_fire && fixable) begin
        corr_pos  <= pos;
        corr_addr <= addr;
        wb_addr   <= addr;
        wb_data   <= fix_data;
      end
    end
  end

endmodule

// File: rtl/dual_code_ecc_ctrl_checker.sv
module dual_code_ecc_ctrl_checker #(
  parameter int WW = 39,
  parameter int PW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req,
  input logic          we,
  input logic          busy,
  input logic          rvalid,
  input logic          err_det,
  input logic          corr_valid,
  input logic [PW-1:0] corr_pos
);

  AST_READ_GIVES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !we && !busy) |=> rvalid); // R2

  AST_FLAGS_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (err_det || corr_valid) |-> rvalid); // R2

  AST_POS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    corr_valid |-> (int'(corr_pos) < WW)); // R4

  AST_CORR_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    corr_valid |-> busy); // R6

  AST_BUSY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy); // R6

  AST_UNCORR_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    err_det |-> (!corr_valid && !busy)); // R7

  AST_STALL_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !rvalid); // R9

endmodule

bind dual_code_ecc_ctrl dual_code_ecc_ctrl_checker #(.WW(WW), .PW(PW)) u_checker (
  .clk(clk), .rst_n(rst_n), .req(req), .we(we), .busy(busy), .rvalid(rvalid),
  .err_det(err_det), .corr_valid(corr_valid), .corr_pos(corr_pos)
);

// File: tb/test_dual_code_ecc_ctrl.sv
module test_dual_code_ecc_ctrl;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        enc_sel = 0, dec_sel = 0, req = 0, we = 0;
  logic [8:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [38:0] flip = '0;
  logic [31:0] rdata;
  logic        rvalid, err_det, busy, corr_valid;
  logic [5:0]  corr_pos;
  logic [8:0]  corr_addr;

  int total = 0, fails = 0;

  always #5 clk = ~clk;

  dual_code_ecc_ctrl i_dual_code_ecc_ctrl (
    .clk(clk), .rst_n(rst_n), .enc_sel(enc_sel), .dec_sel(dec_sel), .req(req), .we(we),
    .addr(addr), .wdata(wdata), .flip(flip), .rdata(rdata), .rvalid(rvalid),
    .err_det(err_det), .busy(busy), .corr_valid(corr_valid), .corr_pos(corr_pos),
    .corr_addr(corr_addr)
  );

  localparam logic [79:0] VEC [8] = '{
    {9'd3,   32'hDEADBEEF, 39'h0},
    {9'd10,  32'h12345678, 39'h1},
    {9'd11,  32'hFFFFFFFF, 39'h80000000},
    {9'd12,  32'hA5A5A5A5, 39'h100000000},
    {9'd13,  32'h00000000, 39'h4000000000},
    {9'd511, 32'h80000001, 39'h100020},
    {9'd0,   32'hCAFEF00D, 39'h800000008},
    {9'd200, 32'h0F0F0F0F, 39'h20000}
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  function automatic logic [6:0] bcol(input bit s, input int i);
    int n = 0;
    logic [6:0] r = '0;
    if (!s) begin
      for (int c = 2; c < 7; c++)
        for (int b = 1; b < c; b++)
          for (int a = 0; a < b; a++) begin
            if (n == i) r = 7'((1 << a) | (1 << b) | (1 << c));
            n++;
          end
    end else begin
      for (int c = 6; c >= 2; c--)
        for (int b = c - 1; b >= 1; b--)
          for (int a = b - 1; a >= 0; a--) begin
            if (n == i) r = 7'((1 << a) | (1 << b) | (1 << c));
            n++;
          end
    end
    return r;
  endfunction

  task automatic op(input logic w, input logic [8:0] a, input logic [31:0] d, input logic [38:0] f);
    @(negedge clk);
    req = 1; we = w; addr = a; wdata = d; flip = f;
    @(negedge clk);
    req = 0; we = 0; flip = '0;
  endtask

  task automatic sel(input logic e, input logic d);
    @(negedge clk);
    enc_sel = e; dec_sel = d;
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    total++; fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy", busy, 0);
    check("R1 rvalid", rvalid, 0);
    check("R1 err_det", err_det, 0);
    check("R1 corr_valid", corr_valid, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 busy after release", busy, 0);

    for (int s = 0; s < 2; s++) begin
      sel(s[0], s[0]);
      for (int v = 0; v < 8; v++) begin
        logic [8:0]  a;
        logic [31:0] d, exp_d;
        logic [38:0] f;
        int          k;
        a = VEC[v][79:71]; d = VEC[v][70:39]; f = VEC[v][38:0];
        op(1, a, d, f);
        op(0, a, 0, 0);
        check("R2 rvalid", rvalid, 1);
        k = $countones(f);
        if (k == 0) begin
          check("R2 clean data", rdata, d);
          check("R2 clean flags", {busy, err_det, corr_valid}, 0);
        end else if (k == 1) begin
          int p = 0;
          for (int b = 0; b < 39; b++) if (f[b]) p = b;
          check(p < 32 ? "R4 corrected data" : "R5 data kept", rdata, d);
          check("R10 corr_valid", corr_valid, 1);
          check(p < 32 ? "R4 corr_pos" : "R5 corr_pos", corr_pos, p);
          check("R4 corr_addr", corr_addr, a);
          check("R6 busy", busy, 1);
          check("R7 no err", err_det, 0);
          @(negedge clk);
          check("R6 busy one cycle", busy, 0);
          op(0, a, 0, 0);
          check("R6 write-back clean", {rvalid, corr_valid, err_det}, 3'b100);
          check("R6 write-back data", rdata, d);
        end else begin
          check("R7 err_det", err_det, 1);
          check("R7 no corr/busy", {corr_valid, busy}, 0);
          op(0, a, 0, 0);
          check("R7 no write-back", err_det, 1);
        end
      end
    end

    for (int s = 0; s < 2; s++) begin
      int idx [3] = '{0, 5, 31};
      sel(s[0], s[0]);
      for (int q = 0; q < 3; q++) begin
        int i = idx[q];
        op(1, 9'(80 + i), 32'(1) << i, {bcol(s[0], i), 32'h0});
        op(0, 9'(80 + i), 0, 0);
        check("R3 column data", rdata, 0);
        check("R3 column pos", {corr_valid, corr_pos}, {1'b1, 6'(i)});
        @(negedge clk);
      end
    end

    sel(0, 0);
    op(1, 9'd50, 32'h11111111, 0);
    op(1, 9'd60, 32'h22222222, 39'h4);
    op(0, 9'd60, 0, 0);
    check("R9 setup busy", busy, 1);
    req = 1; we = 1; addr = 9'd50; wdata = 32'h99999999;
    @(negedge clk);
    req = 0; we = 0;
    check("R9 write ignored rvalid", rvalid, 0);
    op(0, 9'd50, 0, 0);
    check("R9 memory untouched", rdata, 32'h11111111);
    op(1, 9'd61, 32'h33333333, 39'h10);
    op(0, 9'd61, 0, 0);
    req = 1; we = 0; addr = 9'd3;
    @(negedge clk);
    req = 0;
    check("R9 read in busy dropped", rvalid, 0);

    op(1, 9'd70, 32'h1, 0);
    sel(0, 1);
    op(0, 9'd70, 0, 0);
    check("R8 dec code 1 on code 0 word", err_det, 1);
    @(negedge clk);
    dec_sel = 0; req = 1; we = 0; addr = 9'd70;
    @(negedge clk);
    req = 0;
    check("R8 change uses old decoder", err_det, 1);
    op(0, 9'd70, 0, 0);
    check("R8 new decoder clean", {rvalid, err_det, rdata}, {2'b10, 32'h1});
    sel(1, 0);
    op(1, 9'd71, 32'h1, 0);
    op(0, 9'd71, 0, 0);
    check("R8 enc 1 dec 0 mismatch", err_det, 1);
    sel(1, 1);
    op(0, 9'd71, 0, 0);
    check("R8 enc 1 dec 1 clean", {err_det, rdata}, {1'b0, 32'h1});

    summary();
    $finish;
  end
endmodule